// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block holds a word-wide on-chip memory behind a synchronous burst front end. Every rising clock edge captures the address, the chip enable, two address strobes, an advance input and the write controls. Either strobe starts an access at a fresh external address. After that, the advance input walks a 2-bit burst counter that supplies the two low address bits. The counter runs in linear or in interleaved order. Because a strobe may be given on every cycle with no penalty, bursting is optional.

An access is a write when a global write is requested, or when the byte-write enable is high together with at least one byte select. Any other access is a read. A global write stores every byte lane and ignores the byte controls. A byte write stores only the selected lanes. The block presents the effective array address, the registered lane write strobes and a read command for a downstream output stage. Read data follows the read command by one cycle.

A sleep input freezes the block. While it is high, no access is performed. The burst position and the stored contents are both kept.

Top module: `sync_burst_sram`

## Requirements
- R1: Inputs are sampled on the rising edge. `arrayAddr`, `byteStrobe` and `rdCmd` show the access decoded at that edge until the next edge. A write lands in the array at the next edge, and `rdData` is loaded at the edge after `rdCmd` is high.
- R2: When `procStrobe` or `ctrlStrobe` is high with `chipEn` high, the access uses `addrIn`. The burst count restarts at 0, and the order (`linearOrder`) is latched for the whole burst.
- R3: In linear order (`linearOrder`=1 on the load cycle), each advance gives low bits = (start + count) mod 4.
- R4: In interleaved order (`linearOrder`=0 on the load cycle), each advance gives low bits = start XOR count. In both orders the upper address bits stay fixed and the count wraps after four steps.
- R5: During an active burst, a cycle with no strobe and `advance` low repeats the access at the unchanged address (suspend).
- R6: A byte write (`byteWrEn`=1, `globalWr`=0) drives `byteStrobe` equal to `byteSel`. Bit b selects bits [8b+7:8b], and only those lanes change. With `byteWrEn`=0 and `globalWr`=0, `byteSel` has no effect and the access is a read.
- R7: `globalWr`=1 on an access sets every `byteStrobe` bit and writes all lanes, whatever `byteWrEn` and `byteSel` are.
- R8: While `sleep`=1, `rdCmd` and `byteStrobe` are 0 and `arrayAddr` is held. The burst position and the array contents survive, so a later advance continues the burst.
- R9: A strobe with `chipEn`=0 is a deselect. It ends the burst, and no access happens until the next strobe with `chipEn`=1, whatever `advance` does.
- R10: After reset, `arrayAddr`, `byteStrobe`, `rdCmd` and `rdData` are 0 and no burst is active.
- R11: `rdData` holds the word last read until the next read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | External word address |
| chipEn | input | 1 | Chip enable, sampled on strobe cycles |
| procStrobe | input | 1 | First address strobe |
| ctrlStrobe | input | 1 | Second address strobe |
| advance | input | 1 | Step the burst counter |
| byteWrEn | input | 1 | Byte-write enable |
| byteSel | input | NBYTES | Per-lane write selects |
| globalWr | input | 1 | Write all lanes |
| linearOrder | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Block accesses, retain state |
| wrData | input | NBYTES*BYTE_W | Write data |
| arrayAddr | output | ADDR_W | Effective address of the current access |
| byteStrobe | output | NBYTES | Registered lane write strobes |
| rdCmd | output | 1 | Read command for the output stage |
| rdData | output | NBYTES*BYTE_W | Read data, one cycle after rdCmd |

## Verification
The bench uses an 8-bit address with four 8-bit lanes. With this setup, both burst orders can wrap from a start offset in the middle of the group of four, and the upper address bits can be seen to stay fixed. Mixed lane masks can be merged over a global write and read back as a single word. Sleep is exercised with strobe, advance and global write all high at once, to show that neither the burst position nor the array changes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic loadAddr;  // take the external address, restart count
    logic stepAddr;  // advance the burst counter
    logic doAccess;  // an access happens this cycle
    logic isWrite;   // the access is a write
  } ctrlStrobes_t;

  // Low address bits for a burst position
  function automatic logic [1:0] burstOffset(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       linear);
    return linear ? 2'(start + cnt) : (start ^ cnt);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              byteWrEn,
  input  logic [NBYTES-1:0] byteSel,
  input  logic              globalWr,
  input  logic              sleep,
  output ctrlStrobes_t      strobes,
  output logic [NBYTES-1:0] wrMask
);

  logic anyStrobe;
  logic burstActive;

  assign anyStrobe = procStrobe | ctrlStrobe;

  always_comb begin
    strobes = '0;
    if (!sleep) begin
      if (anyStrobe) begin
        if (chipEn) begin
          strobes.loadAddr = 1'b1;
          strobes.doAccess = 1'b1;
        end
      end else if (burstActive) begin
        strobes.doAccess = 1'b1;
        strobes.stepAddr = advance;
      end
    end
    strobes.isWrite = strobes.doAccess & (globalWr | (byteWrEn & (|byteSel)));
  end

  always_comb begin
    if (!strobes.isWrite) wrMask = '0;
    else if (globalWr)    wrMask = '1;
    else                  wrMask = byteSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  burstActive <= 1'b0;
    else if (!sleep && anyStrobe) burstActive <= chipEn;
  end

  // R9: a deselect leaves no burst to continue
  p_deselect_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && anyStrobe && !chipEn) |=> !burstActive);

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [NBYTES-1:0]        wrMask,
  input  logic                     linearOrder,
  input  logic [ADDR_W-1:0]        addrIn,
  input  logic [NBYTES*BYTE_W-1:0] wrData,
  output logic [ADDR_W-1:0]        arrayAddr,
  output logic [NBYTES-1:0]        byteStrobe,
  output logic                     rdCmd,
  output logic [NBYTES*BYTE_W-1:0] rdData
);

  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        burstCnt;
  logic [1:0]        cntNext;
  logic              orderLin;
  logic [ADDR_W-1:0] effNext;
  logic [DATA_W-1:0] wrDataReg;

  always_comb begin
    if (strobes.loadAddr)      cntNext = 2'd0;
    else if (strobes.stepAddr) cntNext = burstCnt + 2'd1;
    else                       cntNext = burstCnt;
  end

  always_comb begin
    if (strobes.loadAddr) effNext = addrIn;
    else effNext = {baseAddr[ADDR_W-1:2], burstOffset(baseAddr[1:0], cntNext, orderLin)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr   <= '0;
      burstCnt   <= 2'd0;
      orderLin   <= 1'b1;
      arrayAddr  <= '0;
      byteStrobe <= '0;
      rdCmd      <= 1'b0;
      wrDataReg  <= '0;
    end else begin
      if (strobes.loadAddr) begin
        baseAddr <= addrIn;
        orderLin <= linearOrder;
      end
      if (strobes.doAccess) begin
        burstCnt  <= cntNext;
        arrayAddr <= effNext;
      end
      byteStrobe <= wrMask;
      rdCmd      <= strobes.doAccess & ~strobes.isWrite;
      wrDataReg  <= wrData;
    end
  end

  // One storage array per byte lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    logic [BYTE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (byteStrobe[b]) laneMem[arrayAddr] <= wrDataReg[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      laneRd <= '0;
      else if (rdCmd) laneRd <= laneMem[arrayAddr];
    end

    assign rdData[b*BYTE_W +: BYTE_W] = laneRd;
  end

  // R11: read data moves only after a read command
  p_rddata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdCmd |=> $stable(rdData));

  // R1: never a read and a write in the same cycle
  p_rw_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCmd && (|byteStrobe)));

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addrIn,
  input  logic                     chipEn,
  input  logic                     procStrobe,
  input  logic                     ctrlStrobe,
  input  logic                     advance,
  input  logic                     byteWrEn,
  input  logic [NBYTES-1:0]        byteSel,
  input  logic                     globalWr,
  input  logic                     linearOrder,
  input  logic                     sleep,
  input  logic [NBYTES*BYTE_W-1:0] wrData,
  output logic [ADDR_W-1:0]        arrayAddr,
  output logic [NBYTES-1:0]        byteStrobe,
  output logic                     rdCmd,
  output logic [NBYTES*BYTE_W-1:0] rdData
);

  ctrlStrobes_t      strobes;
  logic [NBYTES-1:0] wrMask;
  logic              anyStrobe;

  assign anyStrobe = procStrobe | ctrlStrobe;

  burst_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chipEn     (chipEn),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .byteWrEn   (byteWrEn),
    .byteSel    (byteSel),
    .globalWr   (globalWr),
    .sleep      (sleep),
    .strobes    (strobes),
    .wrMask     (wrMask)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrMask      (wrMask),
    .linearOrder (linearOrder),
    .addrIn      (addrIn),
    .wrData      (wrData),
    .arrayAddr   (arrayAddr),
    .byteStrobe  (byteStrobe),
    .rdCmd       (rdCmd),
    .rdData      (rdData)
  );

  // R2: a strobe with chip enable takes the external address
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && anyStrobe && chipEn) |=> (arrayAddr == $past(addrIn)));

  // R5: a suspend cycle keeps the address
  p_suspend_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !anyStrobe && !advance) |=> $stable(arrayAddr));

  // R4: upper bits stay fixed while advancing
  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !anyStrobe && advance) |=>
      (arrayAddr[ADDR_W-1:2] == $past(arrayAddr[ADDR_W-1:2])));

  // R7: a global write on a load cycle strobes every lane
  p_global_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && anyStrobe && chipEn && globalWr) |=> (&byteStrobe));

  // R8: sleep blocks every access
  p_sleep_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (!rdCmd && byteStrobe == '0 && $stable(arrayAddr)));

  // R9: a deselect produces no access
  p_deselect_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && anyStrobe && !chipEn) |=> (!rdCmd && byteStrobe == '0));

endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;

  localparam int ADDR_W = 8;
  localparam int NBYTES = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              chipEn = 1'b0;
  logic              procStrobe = 1'b0;
  logic              ctrlStrobe = 1'b0;
  logic              advance = 1'b0;
  logic              byteWrEn = 1'b0;
  logic [NBYTES-1:0] byteSel = '0;
  logic              globalWr = 1'b0;
  logic              linearOrder = 1'b1;
  logic              sleep = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] arrayAddr;
  logic [NBYTES-1:0] byteStrobe;
  logic              rdCmd;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  sync_burst_sram #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_sync_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .chipEn(chipEn),
    .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe), .advance(advance),
    .byteWrEn(byteWrEn), .byteSel(byteSel), .globalWr(globalWr),
    .linearOrder(linearOrder), .sleep(sleep), .wrData(wrData),
    .arrayAddr(arrayAddr), .byteStrobe(byteStrobe), .rdCmd(rdCmd), .rdData(rdData)
  );

  // Vector: {ps, cs, ce, adv, lin, addr[8], expAddr[8], expRd}
  localparam int NVEC = 14;
  localparam logic [21:0] VECS [NVEC] = '{
    {5'b10101, 8'h16, 8'h16, 1'b1},  // R2 load, linear
    {5'b00011, 8'h00, 8'h17, 1'b1},  // R3 +1
    {5'b00011, 8'h00, 8'h14, 1'b1},  // R3 wrap low bits
    {5'b00011, 8'h00, 8'h15, 1'b1},  // R3
    {5'b00001, 8'h00, 8'h15, 1'b1},  // R5 suspend
    {5'b01100, 8'h2A, 8'h2A, 1'b1},  // R2 second strobe, interleaved
    {5'b00011, 8'h00, 8'h2B, 1'b1},  // R4 2^1
    {5'b00011, 8'h00, 8'h28, 1'b1},  // R4 2^2
    {5'b00011, 8'h00, 8'h29, 1'b1},  // R4 2^3
    {5'b00011, 8'h00, 8'h2A, 1'b1},  // R4 wrap
    {5'b10000, 8'h55, 8'h2A, 1'b0},  // R9 deselect
    {5'b00010, 8'h00, 8'h2A, 1'b0},  // R9 advance without burst
    {5'b10101, 8'h41, 8'h41, 1'b1},  // R2 new load
    {5'b01101, 8'h42, 8'h42, 1'b1}   // R2 back-to-back load
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ps, input logic cs, input logic ce, input logic adv,
                     input logic bwe, input logic [NBYTES-1:0] sel, input logic gw,
                     input logic lin, input logic slp, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d);
    @(negedge clk);
    procStrobe = ps; ctrlStrobe = cs; chipEn = ce; advance = adv;
    byteWrEn = bwe; byteSel = sel; globalWr = gw; linearOrder = lin;
    sleep = slp; addrIn = a; wrData = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 arrayAddr", DATA_W'(arrayAddr), '0);
    check("R10 byteStrobe", DATA_W'(byteStrobe), '0);
    check("R10 rdCmd", DATA_W'(rdCmd), '0);
    check("R10 rdData", rdData, '0);
    @(negedge clk);
    rstN = 1'b1;
    // R10: no burst active, so advance alone does nothing
    cyc(0, 0, 0, 1, 0, '0, 0, 1, 0, '0, '0);
    check("R10 idle after reset", DATA_W'(rdCmd), '0);

    // Burst address table (R1 R2 R3 R4 R5 R9)
    for (int i = 0; i < NVEC; i++) begin
      cyc(VECS[i][21], VECS[i][20], VECS[i][19], VECS[i][18], 0, '0, 0,
          VECS[i][17], 0, VECS[i][16:9], '0);
      check($sformatf("R3 R4 address vector %0d", i), DATA_W'(arrayAddr), DATA_W'(VECS[i][8:1]));
      check($sformatf("R9 rdCmd vector %0d", i), DATA_W'(rdCmd), DATA_W'(VECS[i][0]));
    end

    // R7: global write overrides byte controls
    cyc(1, 0, 1, 0, 1, 4'b0000, 1, 1, 0, 8'h10, 32'hA1B2C3D4);
    check("R7 byteStrobe", DATA_W'(byteStrobe), 32'hF);
    check("R7 rdCmd", DATA_W'(rdCmd), '0);
    // R6: byte write of lanes 0 and 2
    cyc(0, 1, 1, 0, 1, 4'b0101, 0, 1, 0, 8'h10, 32'h11223344);
    check("R6 byteStrobe", DATA_W'(byteStrobe), 32'h5);
    // R6: selects without enable give a read
    cyc(0, 1, 1, 0, 0, 4'b1111, 0, 1, 0, 8'h10, 32'hFFFFFFFF);
    check("R6 no write strobe", DATA_W'(byteStrobe), '0);
    check("R6 read command", DATA_W'(rdCmd), 32'h1);
    // R1 R11: data one cycle after the read command
    cyc(1, 0, 0, 0, 0, '0, 0, 1, 0, 8'h00, '0);
    check("R1 R11 merged read data", rdData, 32'hA122C344);

    // R8: sleep blocks an access and keeps state
    cyc(1, 0, 1, 0, 0, '0, 0, 1, 0, 8'h30, '0);
    check("R8 burst start", DATA_W'(arrayAddr), 32'h30);
    cyc(1, 0, 1, 1, 0, '0, 1, 1, 1, 8'h10, 32'h0);
    check("R8 no read in sleep", DATA_W'(rdCmd), '0);
    check("R8 no write in sleep", DATA_W'(byteStrobe), '0);
    check("R8 address held", DATA_W'(arrayAddr), 32'h30);
    cyc(0, 0, 0, 1, 0, '0, 0, 1, 0, 8'h00, '0);
    check("R8 burst resumes", DATA_W'(arrayAddr), 32'h31);
    cyc(1, 0, 1, 0, 0, '0, 0, 1, 0, 8'h10, '0);
    cyc(1, 0, 0, 0, 0, '0, 0, 1, 0, 8'h00, '0);
    check("R8 contents kept", rdData, 32'hA122C344);
    cyc(0, 0, 0, 0, 0, '0, 0, 1, 0, 8'h00, '0);
    check("R11 rdData held", rdData, 32'hA122C344);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule